// File: doc/BRIEF.md
# Dual-Network Fixed-Point FIR Multiply-Accumulate Engine

This block computes finite impulse response outputs one tap per clock. It holds two identical filter networks. Each network has a short delay line of signed 16-bit samples, a bank of coefficients and a single multiply-accumulate stage. Coefficients arrive as 16-bit signed words. On the way into the bank they are cut to 12 bits, rounding toward zero. Each accepted sample starts a pass over every tap. In a pass, each 28-bit product loses its four lowest bits, is sign-extended and is added into a 32-bit accumulator that wraps on overflow.

In single mode, only the first network runs, and its accumulator is the block result. In cascade mode, every finished output of the first network sends accumulator bits [23:8] into the second network as a new sample. The second network's accumulator then becomes the result, so the two networks form one longer two-stage filter. The cascade select is only changed while both networks are idle. A sample source waits on the ready output, because the first network accepts a new sample only between passes.

Top module: `fir_mac_pair`

## Requirements
- R1: After reset, `res_valid` is 0 and `samp_ready` is 1. Every delay-line entry and every stored coefficient reads as zero.
- R2: A coefficient written with a non-negative value (bit 15 clear) is stored as its bits [15:4], for example 0x0017 becomes 1 and 0x7FF5 becomes 2047.
- R3: A coefficient written with a negative value is stored as bits [15:4] plus one when any of bits [3:0] is set. This gives round-toward-zero: 0xFFE9 (-23) becomes -1, 0xFFFF becomes 0, and 0x8000 stays -2048.
- R4: The 16x12 product is formed at its full 28-bit width. A sample of 0x8000 times a stored coefficient of -2048 contributes +0x400000 to the accumulator.
- R5: Each product drops its four least significant bits with floor truncation before it is sign-extended to 32 bits and accumulated. Sample -1 times coefficient 1 contributes -1, and sample +1 times coefficient 1 contributes 0.
- R6: In single mode, the result is the sum over taps k of truncate(d[k] * c[k]), modulo 2^32. Here d[0] is the newest sample and c[k] is the coefficient at index k. `res_valid` is high for exactly one cycle, NTAPS clock edges after the edge that accepted the sample.
- R7: While a pass runs, `samp_ready` is 0, and a sample presented with `samp_valid` is ignored: it never enters the delay line.
- R8: Every accepted sample shifts the delay line by one place and drops the oldest entry.
- R9: In cascade mode, bits [23:8] of the first network's accumulator enter the second network once per completed output. The result port then shows only the second network's result, with `res_valid` 2*NTAPS+1 edges after the accepting edge.
- R10: A coefficient write goes only to the network chosen by `coef_net` (0 = first, 1 = second), at tap index `coef_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_net | input | 1 | Target network of the write (0 first, 1 second) |
| coef_idx | input | $clog2(NTAPS) | Tap index of the write |
| coef_data | input | 16 | Signed coefficient before reduction |
| samp_valid | input | 1 | Sample offered |
| samp_data | input | 16 | Signed input sample |
| samp_ready | output | 1 | First network is idle and takes a sample |
| cascade_en | input | 1 | 1 selects the two-stage cascade |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 32 | Accumulated result |

## Verification
A single-mode result is due NTAPS edges after the accepting edge. A cascade result is due 2*NTAPS+1 edges after it, because the second network takes its sample on the edge after the first network's result cycle. The bench drives each sample at a falling edge and then counts rising edges. It reads `res_valid` at the falling edge that follows each one, so the first cycle with the strobe high gives the measured latency, which is compared with the due count. The next falling edge must show the strobe low. For the ignored-sample case, the bench offers a stray sample one cycle into a pass and checks that `samp_ready` is low. The outputs of the next two passes then show whether the delay line moved.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  localparam int SAMP_W    = 16;
  localparam int COEF_IN_W = 16;
  localparam int COEF_CUT  = 4;
  localparam int COEF_W    = COEF_IN_W - COEF_CUT;
  localparam int PROD_W    = SAMP_W + COEF_W;
  localparam int PROD_DROP = 4;
  localparam int ACC_W     = 32;
  localparam int CASC_LSB  = 8;
endpackage

// File: rtl/fir_coef_round.sv
module fir_coef_round #(
  parameter  int IN_W  = 16,
  parameter  int CUT   = 4,
  localparam int OUT_W = IN_W - CUT
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] cut
);
  logic neg;
  logic frac_any;

  // Toward zero: negatives with a nonzero dropped nibble move up by one.
  always_comb begin
    neg      = raw[IN_W-1];
    frac_any = |raw[CUT-1:0];
    cut      = raw[IN_W-1:CUT] + OUT_W'(neg & frac_any);
  end
endmodule

// File: rtl/fir_prod_scale.sv
module fir_prod_scale
  import fir_mac_pkg::*;
(
  input  logic signed [SAMP_W-1:0] samp,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  term
);
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(samp) * PROD_W'(coef);
    term = ACC_W'($signed(prod[PROD_W-1:PROD_DROP]));
  end
endmodule

// File: rtl/fir_mac_net.sv
module fir_mac_net
  import fir_mac_pkg::*;
#(
  parameter  int NTAPS = 8,
  localparam int IDX_W = $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [SAMP_W-1:0]    in_data,
  output logic                 in_ready,
  input  logic                 cw_en,
  input  logic [IDX_W-1:0]     cw_idx,
  input  logic [COEF_IN_W-1:0] cw_data,
  output logic [ACC_W-1:0]     acc_out,
  output logic                 done
);
  logic signed [SAMP_W-1:0] dl_q [NTAPS];
  logic signed [SAMP_W-1:0] dl_d [NTAPS];
  logic signed [COEF_W-1:0] coef_q [NTAPS];
  logic [COEF_W-1:0]        coef_cut;
  logic                     busy_q, busy_d;
  logic                     done_q, done_d;
  logic [IDX_W-1:0]         tap_q, tap_d;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic signed [ACC_W-1:0]  term;
  logic                     take, last, acc_en;

  fir_coef_round #(.IN_W(COEF_IN_W), .CUT(COEF_CUT)) u_round (
    .raw (cw_data),
    .cut (coef_cut)
  );

  fir_prod_scale u_prod (
    .samp (dl_q[tap_q]),
    .coef (coef_q[tap_q]),
    .term (term)
  );

  assign dl_d[0] = in_data;
  for (genvar i = 1; i < NTAPS; i++) begin : g_shift
    assign dl_d[i] = dl_q[i-1];
  end

  always_comb begin
    take   = in_valid & ~busy_q;
    last   = (tap_q == IDX_W'(NTAPS - 1));
    acc_en = take | busy_q;
    acc_d  = take ? '0 : acc_q + term;
    tap_d  = take ? '0 : tap_q + IDX_W'(1);
    busy_d = take | (busy_q & ~last);
    done_d = busy_q & last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tap_q  <= '0;
      acc_q  <= '0;
      for (int i = 0; i < NTAPS; i++) begin
        dl_q[i]   <= '0;
        coef_q[i] <= '0;
      end
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (acc_en) begin
        acc_q <= acc_d;
        tap_q <= tap_d;
      end
      if (take) begin
        for (int i = 0; i < NTAPS; i++) dl_q[i] <= dl_d[i];
      end
      if (cw_en) coef_q[cw_idx] <= coef_cut;
    end
  end

  assign in_ready = ~busy_q;
  assign acc_out  = acc_q;
  assign done     = done_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && acc_out == '0)); // R6
  AST_DONE_ENDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (in_ready && $past(!in_ready))); // R6
  AST_BUSY_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(dl_q[0])); // R7
  AST_COEF_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cw_en |=> (coef_q[$past(cw_idx)] == '0 ||
               coef_q[$past(cw_idx)][COEF_W-1] == $past(cw_data[COEF_IN_W-1]))); // R3
endmodule

// File: rtl/fir_mac_pair.sv
module fir_mac_pair
  import fir_mac_pkg::*;
#(
  parameter  int NTAPS = 8,
  localparam int IDX_W = $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coef_we,
  input  logic                 coef_net,
  input  logic [IDX_W-1:0]     coef_idx,
  input  logic [COEF_IN_W-1:0] coef_data,
  input  logic                 samp_valid,
  input  logic [SAMP_W-1:0]    samp_data,
  output logic                 samp_ready,
  input  logic                 cascade_en,
  output logic                 res_valid,
  output logic [ACC_W-1:0]     res_data
);
  logic              net_vin  [2];
  logic [SAMP_W-1:0] net_din  [2];
  logic              net_rdy  [2];
  logic [ACC_W-1:0]  net_acc  [2];
  logic              net_done [2];
  logic              net_we   [2];

  always_comb begin
    net_vin[0] = samp_valid;
    net_din[0] = samp_data;
    net_vin[1] = cascade_en & net_done[0];
    net_din[1] = net_acc[0][CASC_LSB+SAMP_W-1:CASC_LSB];
    net_we[0]  = coef_we & ~coef_net;
    net_we[1]  = coef_we & coef_net;
  end

  for (genvar n = 0; n < 2; n++) begin : g_net
    fir_mac_net #(.NTAPS(NTAPS)) u_net (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (net_vin[n]),
      .in_data  (net_din[n]),
      .in_ready (net_rdy[n]),
      .cw_en    (net_we[n]),
      .cw_idx   (coef_idx),
      .cw_data  (coef_data),
      .acc_out  (net_acc[n]),
      .done     (net_done[n])
    );
  end

  assign samp_ready = net_rdy[0];
  assign res_valid  = cascade_en ? net_done[1] : net_done[0];
  assign res_data   = cascade_en ? net_acc[1]  : net_acc[0];

  AST_CASCADE_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade_en && net_done[0]) |=> !net_rdy[1]); // R9
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6
endmodule

// File: tb/fir_mac_pair_tb.sv
module fir_mac_pair_tb;
  localparam int CLK_P = 10;
  localparam int NT    = 8;
  localparam int IW    = $clog2(NT);

  typedef struct packed {
    logic [15:0] s;
    logic [31:0] e;
  } vec_t;
  // Coefficient k reduces to k+1; sample 16*m adds m*(k+1) at tap k.
  localparam vec_t TBL [5] = '{
    '{16'h0010, 32'd1},
    '{16'h0020, 32'd4},
    '{16'hFFF0, 32'd6},
    '{16'h0040, 32'd12},
    '{16'hFFE0, 32'd16}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic coef_we, coef_net;
  logic [IW-1:0] coef_idx;
  logic [15:0] coef_data;
  logic samp_valid;
  logic [15:0] samp_data;
  logic samp_ready;
  logic cascade_en;
  logic res_valid;
  logic [31:0] res_data;

  int n_run = 0;
  int n_fail = 0;
  int dla [NT];
  int dlb [NT];
  int ca [NT];
  int cb [NT];

  always #(CLK_P/2) clk = ~clk;

  fir_mac_pair #(.NTAPS(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_net(coef_net),
    .coef_idx(coef_idx), .coef_data(coef_data), .samp_valid(samp_valid),
    .samp_data(samp_data), .samp_ready(samp_ready), .cascade_en(cascade_en),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fir_ref(input int d [NT], input int c [NT]);
    longint acc = 0;
    for (int k = 0; k < NT; k++) acc += (longint'(d[k]) * longint'(c[k])) >>> 4;
    return acc[31:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    coef_we = 1'b0; coef_net = 1'b0; coef_idx = '0; coef_data = '0;
    samp_valid = 1'b0; samp_data = '0;
    for (int k = 0; k < NT; k++) begin dla[k] = 0; dlb[k] = 0; ca[k] = 0; cb[k] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_coef(input logic net, input int idx, input logic [15:0] v);
    @(negedge clk);
    coef_we = 1'b1; coef_net = net; coef_idx = IW'(idx); coef_data = v;
    @(negedge clk);
    coef_we = 1'b0;
    if (net) cb[idx] = int'($signed(v)) / 16;
    else     ca[idx] = int'($signed(v)) / 16;
  endtask

  // Sends one sample, measures latency and value against the model.
  task automatic push(input logic [15:0] s, input bit poke, input string tag,
                      output logic [31:0] got);
    logic [31:0] exp_v, a_out;
    int lat, exp_lat;
    for (int k = NT-1; k > 0; k--) dla[k] = dla[k-1];
    dla[0] = int'($signed(s));
    a_out = fir_ref(dla, ca);
    if (cascade_en) begin
      for (int k = NT-1; k > 0; k--) dlb[k] = dlb[k-1];
      dlb[0] = int'($signed(a_out[23:8]));
      exp_v = fir_ref(dlb, cb);
      exp_lat = 2*NT + 1;
    end else begin
      exp_v = a_out;
      exp_lat = NT;
    end
    @(negedge clk);
    samp_data = s; samp_valid = 1'b1;
    @(posedge clk);
    #1;
    samp_valid = poke;
    samp_data = ~s;
    lat = 0; got = '0;
    for (int i = 1; i <= 4*NT; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 1) begin
        if (poke) chk({tag, " R7 ready low in pass"}, 32'(samp_ready), 32'd0);
        samp_valid = 1'b0;
      end
      if (res_valid) begin
        lat = i; got = res_data;
        break;
      end
    end
    chk({tag, cascade_en ? " R9 latency" : " R6 latency"}, 32'(lat), 32'(exp_lat));
    chk({tag, " value"}, got, exp_v);
    @(negedge clk);
    chk({tag, " R6 one-cycle strobe"}, 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] got;
    cascade_en = 1'b0;
    do_reset();
    // R1 reset state
    chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
    chk("R1 samp_ready after reset", 32'(samp_ready), 32'd1);

    // R6 R8 table walk, single mode
    for (int k = 0; k < NT; k++) wr_coef(1'b0, k, 16'((k+1)*16));
    foreach (TBL[i]) begin
      push(TBL[i].s, 1'b0, "R8 table", got);
      chk("R6 table hand value", got, TBL[i].e);
    end

    // R7 stray sample while busy, then confirm line unchanged
    push(16'h0030, 1'b1, "R7 poked pass", got);
    chk("R7 hand value", got, 32'd23);
    push(16'h0000, 1'b0, "R7 follow-up", got);
    chk("R7 line not shifted by stray", got, 32'd30);

    // R2 R3 R4 R5 rounding and truncation on tap 0
    do_reset();
    wr_coef(1'b0, 0, 16'h0017); push(16'h0100, 1'b0, "R2 pos 0x0017", got);
    chk("R2 0x0017 -> 1", got, 32'h0000_0010);
    wr_coef(1'b0, 0, 16'h7FF5); push(16'h0010, 1'b0, "R2 pos 0x7FF5", got);
    chk("R2 0x7FF5 -> 2047", got, 32'd2047);
    wr_coef(1'b0, 0, 16'hFFE9); push(16'h0100, 1'b0, "R3 neg -23", got);
    chk("R3 -23 -> -1", got, 32'hFFFF_FFF0);
    wr_coef(1'b0, 0, 16'hFFFF); push(16'h7FFF, 1'b0, "R3 neg -1", got);
    chk("R3 -1 -> 0", got, 32'h0000_0000);
    wr_coef(1'b0, 0, 16'h8000); push(16'h8000, 1'b0, "R4 full scale", got);
    chk("R4 both negative full scale", got, 32'h0040_0000);
    wr_coef(1'b0, 0, 16'h0010); push(16'hFFFF, 1'b0, "R5 floor neg", got);
    chk("R5 -1 x 1", got, 32'hFFFF_FFFF);
    push(16'h0001, 1'b0, "R5 floor pos", got);
    chk("R5 +1 x 1", got, 32'h0000_0000);

    // R10 write routing by network and index
    do_reset();
    wr_coef(1'b0, 5, 16'h0030);
    wr_coef(1'b1, 5, 16'h7FF0);
    wr_coef(1'b1, 0, 16'h7FF0);
    push(16'h0010, 1'b0, "R10 step", got);
    chk("R10 tap0 of first untouched", got, 32'd0);
    for (int j = 0; j < 5; j++) push(16'h0000, 1'b0, "R10 zeros", got);
    chk("R10 tap5 of first", got, 32'd3);

    // R9 cascade
    do_reset();
    cascade_en = 1'b1;
    wr_coef(1'b0, 0, 16'h7FF0);
    wr_coef(1'b0, 1, 16'hC000);
    wr_coef(1'b1, 0, 16'h0010);
    wr_coef(1'b1, 1, 16'hFFE0);
    push(16'h4000, 1'b0, "R9 cascade s0", got);
    push(16'hC123, 1'b0, "R9 cascade s1", got);
    push(16'h7FFF, 1'b0, "R9 cascade s2", got);
    cascade_en = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule